// File: doc/BRIEF.md
# Sectored Flash Operation Controller

This block is the command and sequencing engine that sits between a processor bus and a sectored flash array. The array is split into a main region of eight sectors and a boot region of four sectors. Each sector carries its own write-protect bit. Software issues byte-program, whole-sector erase, erase-suspend, erase-resume and identification commands through bus writes that carry a command code. The controller checks protection, then holds a run request to the array for as long as the array needs to finish the timed operation.

The block never changes array contents on a plain bus write. While an operation is running, a read returns a status byte instead of array data. A bit in that byte alternates on each read, so software can poll until it stops alternating. Software may also watch the active-low busy pin. A sector erase can be paused so that other sectors can be read, and then continued from where it stopped. An identification mode returns per-sector protect flags and a device code.

Top module: `flash_sector_ctrl`

## Requirements
- R1: After reset the ready pin `rdy_busy_n` is 1, `arr_run` is 0, and a read with no sector selected returns 0x00.
- R2: Sector i is selected by `sect_sel[i]` and protected by `prot_bits[i]`. Indices 0-7 are the main region and 8-11 are the boot region. When several select bits are set, the lowest-numbered sector is used.
- R3: Command code 1 (program) in idle, aimed at an unprotected sector, writes `bus_wdata` at offset `bus_addr`. `rdy_busy_n` goes low on the write edge and returns high on the edge after `arr_done` is sampled, so a run of D array cycles keeps the pin low for D+1 cycles.
- R4: Command code 2 (erase) in idle, aimed at an unprotected sector, erases every byte of that sector only. The sector number on `arr_sect` stays stable while `arr_run` is high.
- R5: A program or erase aimed at a protected sector sets status bit 1 (error). It leaves `rdy_busy_n` at 1 and `arr_run` at 0, and the array is unchanged. The next accepted program or erase clears the error bit.
- R6: Command code 0 (plain write) never changes array contents or controller state. Command codes that are not valid in the current state are ignored.
- R7: Command code 3 (suspend) is honoured only during an erase. While suspended, `arr_run` is 0, `rdy_busy_n` is 1 and status bit 2 is set. Reads of other sectors return array data, and reads of the sector being erased return the status byte.
- R8: Command code 4 (resume) is honoured only while suspended. It restarts the run request, and the total number of cycles with `arr_run` high matches an erase that was never paused.
- R9: Status byte layout: bit 0 toggle, bit 1 error, bit 2 suspended, bit 3 program or erase running, upper bits 0. Read data appears on `bus_rdata` the cycle after `bus_rd`. During a program or erase, every read returns the status byte.
- R10: The toggle bit inverts on each status-byte read while a program, erase or suspended erase is in progress. At any other time it holds its value.
- R11: Command code 5 in idle enters identification mode. There, a read of a selected sector returns its protect bit in bit 0, and a read with no sector selected returns the device code. Command code 6 returns to normal array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | OFF_W | Byte offset within the selected sector |
| bus_wdata | input | DATA_W | Write data for a program command |
| bus_cmd | input | 3 | Command code carried by a bus write |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| sect_sel | input | NSECT | Sector select lines, one per sector |
| prot_bits | input | NSECT | Per-sector protect flags |
| bus_rdata | output | DATA_W | Registered read data |
| rdy_busy_n | output | 1 | 1 = ready, 0 = program or erase running |
| arr_run | output | 1 | Run request to the array |
| arr_erase | output | 1 | 1 = erase, 0 = program |
| arr_sect | output | SECT_W | Target sector of the running operation |
| arr_off | output | OFF_W | Target offset of a program |
| arr_wdata | output | DATA_W | Data of a program |
| arr_done | input | 1 | One-cycle pulse from the array when the operation completes |
| arr_rd_sect | output | SECT_W | Sector index for an array read |
| arr_rd_off | output | OFF_W | Offset for an array read |
| arr_rd_data | input | DATA_W | Array read data, combinational |

## Verification
The bench builds the controller with four-byte sectors (OFF_W = 2), keeping the default twelve sectors and byte-wide data. With that configuration every byte of every sector can be read, plainly written and reprogrammed. Every sector can also be tried under protection for both program and erase. The behavioural array uses short run lengths of 8 and 9 cycles. These are still long enough for several status reads during a program and for a suspend in the middle of an erase, so exact busy windows and total run cycles can be predicted from the run lengths alone.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_INFO  = 3'd4
  } fsc_state_e;

  localparam logic [2:0] CMD_NONE    = 3'd0;
  localparam logic [2:0] CMD_PROG    = 3'd1;
  localparam logic [2:0] CMD_ERASE   = 3'd2;
  localparam logic [2:0] CMD_SUSPEND = 3'd3;
  localparam logic [2:0] CMD_RESUME  = 3'd4;
  localparam logic [2:0] CMD_INFO    = 3'd5;
  localparam logic [2:0] CMD_EXIT    = 3'd6;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_PROT   = 2'd2,
    SRC_ID     = 2'd3
  } rd_src_e;
endpackage

// File: rtl/fsc_sector_pick.sv
module fsc_sector_pick #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  sel,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // lowest-numbered asserted line wins
  always_comb begin
    hit = |sel;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fsc_status_unit.sv
module fsc_status_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_err,
  input  logic              clr_err,
  input  logic              adv,
  input  logic              busy,
  input  logic              susp,
  output logic              err_o,
  output logic [DATA_W-1:0] stat_o
);
  logic err_q;
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      if (set_err)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
      if (adv)          tog_q <= ~tog_q;
    end
  end

  assign err_o  = err_q;
  assign stat_o = {{(DATA_W-4){1'b0}}, busy, susp, err_q, tog_q};
endmodule

// File: rtl/fsc_read_path.sv
module fsc_read_path
  import fsc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [DATA_W-1:0] stat,
  input  logic              prot_bit,
  input  logic [DATA_W-1:0] dev_id,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    case (src)
      SRC_STATUS: nxt = stat;
      SRC_PROT:   nxt = {{(DATA_W-1){1'b0}}, prot_bit};
      SRC_ID:     nxt = dev_id;
      default:    nxt = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= nxt;
  end
endmodule

// File: rtl/flash_sector_ctrl.sv
module flash_sector_ctrl
  import fsc_pkg::*;
#(
  parameter int NUM_MAIN = 8,
  parameter int NUM_BOOT = 4,
  parameter int OFF_W    = 8,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEV_ID = 'hA5,
  localparam int NSECT  = NUM_MAIN + NUM_BOOT,
  localparam int SECT_W = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [2:0]        bus_cmd,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NSECT-1:0]  sect_sel,
  input  logic [NSECT-1:0]  prot_bits,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rdy_busy_n,
  output logic              arr_run,
  output logic              arr_erase,
  output logic [SECT_W-1:0] arr_sect,
  output logic [OFF_W-1:0]  arr_off,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic              arr_done,
  output logic [SECT_W-1:0] arr_rd_sect,
  output logic [OFF_W-1:0]  arr_rd_off,
  input  logic [DATA_W-1:0] arr_rd_data
);
  fsc_state_e        state_q, state_n;
  logic              sel_hit;
  logic [SECT_W-1:0] sel_idx;
  logic              set_err, accept;
  logic              err_flag;
  logic [DATA_W-1:0] stat_byte;
  logic              running, stat_adv;
  rd_src_e           rd_src;
  logic              wr_op;

  fsc_sector_pick #(.N(NSECT), .IW(SECT_W)) u_pick (
    .sel (sect_sel),
    .hit (sel_hit),
    .idx (sel_idx)
  );

  assign wr_op   = bus_wr && (bus_cmd == CMD_PROG || bus_cmd == CMD_ERASE) && sel_hit;
  assign running = (state_q == ST_PROG) || (state_q == ST_ERASE);

  always_comb begin
    state_n = state_q;
    set_err = 1'b0;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wr_op) begin
          if (prot_bits[sel_idx]) begin
            set_err = 1'b1;
          end else begin
            accept  = 1'b1;
            state_n = (bus_cmd == CMD_ERASE) ? ST_ERASE : ST_PROG;
          end
        end else if (bus_wr && bus_cmd == CMD_INFO) begin
          state_n = ST_INFO;
        end
      end
      ST_PROG:  if (arr_done) state_n = ST_IDLE;
      ST_ERASE: begin
        if (arr_done)                            state_n = ST_IDLE;
        else if (bus_wr && bus_cmd == CMD_SUSPEND) state_n = ST_SUSP;
      end
      ST_SUSP:  if (bus_wr && bus_cmd == CMD_RESUME) state_n = ST_ERASE;
      ST_INFO:  if (bus_wr && bus_cmd == CMD_EXIT)   state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      arr_run    <= 1'b0;
      rdy_busy_n <= 1'b1;
      arr_erase  <= 1'b0;
      arr_sect   <= '0;
      arr_off    <= '0;
      arr_wdata  <= '0;
    end else begin
      state_q    <= state_n;
      arr_run    <= (state_n == ST_PROG) || (state_n == ST_ERASE);
      rdy_busy_n <= !((state_n == ST_PROG) || (state_n == ST_ERASE));
      if (accept) begin
        arr_erase <= (bus_cmd == CMD_ERASE);
        arr_sect  <= sel_idx;
        arr_off   <= bus_addr;
        arr_wdata <= bus_wdata;
      end
    end
  end

  // read source selection
  always_comb begin
    rd_src = SRC_ARRAY;
    if (state_q == ST_INFO)
      rd_src = sel_hit ? SRC_PROT : SRC_ID;
    else if (running || !sel_hit)
      rd_src = SRC_STATUS;
    else if (state_q == ST_SUSP && sel_idx == arr_sect)
      rd_src = SRC_STATUS;
  end

  assign stat_adv = bus_rd && (rd_src == SRC_STATUS) && (running || state_q == ST_SUSP);

  fsc_status_unit #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_err (set_err),
    .clr_err (accept),
    .adv     (stat_adv),
    .busy    (running),
    .susp    (state_q == ST_SUSP),
    .err_o   (err_flag),
    .stat_o  (stat_byte)
  );

  assign arr_rd_sect = sel_idx;
  assign arr_rd_off  = bus_addr;

  fsc_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .src      (rd_src),
    .arr_data (arr_rd_data),
    .stat     (stat_byte),
    .prot_bit (prot_bits[sel_idx]),
    .dev_id   (DEV_ID),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk
  import fsc_pkg::*;
#(
  parameter int NSECT  = 12,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input fsc_state_e        state_q,
  input logic              bus_wr,
  input logic [2:0]        bus_cmd,
  input logic              sel_hit,
  input logic [SECT_W-1:0] sel_idx,
  input logic [NSECT-1:0]  prot_bits,
  input logic              rdy_busy_n,
  input logic              arr_run,
  input logic              arr_done,
  input logic [SECT_W-1:0] arr_sect,
  input logic              err_flag
);
  // R5
  prot_block_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && bus_wr && (bus_cmd == CMD_PROG || bus_cmd == CMD_ERASE)
     && sel_hit && prot_bits[sel_idx]) |=> (rdy_busy_n && !arr_run && err_flag));

  // R7
  susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUSP && $past(state_q) != ST_SUSP) |-> ($past(state_q) == ST_ERASE));

  // R7
  susp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUSP) |-> (!arr_run && rdy_busy_n));

  // R8
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUSP && bus_wr && bus_cmd == CMD_RESUME) |=> (arr_run && !rdy_busy_n));

  // R6
  plain_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_cmd == CMD_NONE && !arr_done) |=> $stable(state_q));

  // R3
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PROG && arr_done) |=> rdy_busy_n);

  // R4
  sect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_run && $past(arr_run)) |-> $stable(arr_sect));
endmodule

bind flash_sector_ctrl fsc_chk #(.NSECT(NSECT), .SECT_W(SECT_W)) u_fsc_chk (
  .clk        (clk),
  .rst        (rst),
  .state_q    (state_q),
  .bus_wr     (bus_wr),
  .bus_cmd    (bus_cmd),
  .sel_hit    (sel_hit),
  .sel_idx    (sel_idx),
  .prot_bits  (prot_bits),
  .rdy_busy_n (rdy_busy_n),
  .arr_run    (arr_run),
  .arr_done   (arr_done),
  .arr_sect   (arr_sect),
  .err_flag   (err_flag)
);

// File: tb/tb_flash_sector_ctrl.sv
module tb_flash_sector_ctrl;
  localparam int NS = 12;
  localparam int OW = 2;
  localparam int NB = 4;
  localparam int PROG_DUR  = 8;
  localparam int ERASE_DUR = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [2:0]    bus_cmd = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [NS-1:0] sect_sel = '0, prot_bits = '0;
  logic [7:0]    bus_rdata;
  logic          rdy_busy_n, arr_run, arr_erase, arr_done;
  logic [3:0]    arr_sect, arr_rd_sect;
  logic [OW-1:0] arr_off, arr_rd_off;
  logic [7:0]    arr_wdata, arr_rd_data;

  always #2 clk = ~clk;

  flash_sector_ctrl #(.OFF_W(OW), .DEV_ID(8'hA5)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cmd(bus_cmd),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .sect_sel(sect_sel), .prot_bits(prot_bits),
    .bus_rdata(bus_rdata), .rdy_busy_n(rdy_busy_n), .arr_run(arr_run), .arr_erase(arr_erase),
    .arr_sect(arr_sect), .arr_off(arr_off), .arr_wdata(arr_wdata), .arr_done(arr_done),
    .arr_rd_sect(arr_rd_sect), .arr_rd_off(arr_rd_off), .arr_rd_data(arr_rd_data)
  );

  // behavioural array with fixed run lengths
  logic [7:0] mem [NS][NB];
  int cnt;
  logic done_q;
  int run_cycles = 0;
  assign arr_done = done_q;
  assign arr_rd_data = (int'(arr_rd_sect) < NS) ? mem[arr_rd_sect][arr_rd_off] : 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++)
        for (int o = 0; o < NB; o++) mem[s][o] <= 8'(s * 16 + o);
      cnt <= 0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (arr_run && !done_q) begin
        if (cnt == (arr_erase ? ERASE_DUR : PROG_DUR) - 1) begin
          cnt <= 0;
          done_q <= 1'b1;
          if (arr_erase) for (int o = 0; o < NB; o++) mem[arr_sect][o] <= 8'hFF;
          else mem[arr_sect][arr_off] <= arr_wdata;
        end else cnt <= cnt + 1;
      end
    end
  end

  always @(posedge clk) if (!rst && arr_run) run_cycles <= run_cycles + 1;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] expm [NS][NB];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [NS-1:0] sel,
                        input logic [OW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cmd = c; sect_sel = sel; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_cmd = '0; sect_sel = '0;
  endtask

  task automatic do_rd(input logic [NS-1:0] sel, input logic [OW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    sect_sel = sel; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; sect_sel = '0;
    v = bus_rdata;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rdy_busy_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v1, v2, v3;
    int n, r0;
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < NB; o++) expm[s][o] = 8'(s * 16 + o);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", int'(rdy_busy_n), 1);
    check("R1 run", int'(arr_run), 0);
    do_rd('0, 0, v);
    check("R1 status", v, 8'h00);

    // R2 / R6: full read sweep, plain writes ignored
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < NB; o++) begin
        do_cmd(3'd0, NS'(1) << s, OW'(o), ~expm[s][o]);
        do_rd(NS'(1) << s, OW'(o), v);
        check("R6 plain write ignored", v, expm[s][o]);
      end
    for (int s = 0; s < NS - 1; s++) begin
      do_rd((NS'(1) << s) | (NS'(1) << (NS - 1)), 2, v);
      check("R2 lowest select wins", v, expm[s][2]);
    end

    // R3: program every sector, exact busy window
    for (int s = 0; s < NS; s++) begin
      r0 = run_cycles;
      do_cmd(3'd1, NS'(1) << s, OW'(s % NB), 8'h3C ^ 8'(s));
      wait_ready(n);
      check("R3 busy cycles", n, PROG_DUR + 1);
      expm[s][s % NB] = 8'h3C ^ 8'(s);
      do_rd(NS'(1) << s, OW'(s % NB), v);
      check("R3 programmed byte", v, expm[s][s % NB]);
      check("R3 run cycles", run_cycles - r0, PROG_DUR + 1);
    end

    // R9 / R10: status during a program
    do_cmd(3'd1, NS'(1) << 1, 0, 8'h77);
    expm[1][0] = 8'h77;
    do_rd('0, 0, v1);
    do_rd('0, 0, v2);
    do_rd(NS'(1), 0, v3);
    check("R9 busy bit", int'(v1[7:1]), 7'h04);
    check("R9 sector read gives status", int'(v3[7:1]), 7'h04);
    check("R10 toggle flips", int'(v1[0] ^ v2[0]), 1);
    check("R10 toggle flips again", int'(v2[0] ^ v3[0]), 1);
    wait_ready(n);
    do_rd('0, 0, v1);
    do_rd('0, 0, v2);
    check("R10 toggle frozen when idle", int'(v1[0] ^ v2[0]), 0);
    check("R9 idle status", int'(v1[7:1]), 0);

    // R6: suspend during program ignored, resume in idle ignored
    r0 = run_cycles;
    do_cmd(3'd1, NS'(1) << 2, 1, 8'h5A);
    expm[2][1] = 8'h5A;
    do_cmd(3'd3, '0, 0, 0);
    check("R6 suspend in program ignored", int'({rdy_busy_n, arr_run}), 1);
    wait_ready(n);
    check("R6 program run length", run_cycles - r0, PROG_DUR + 1);
    do_cmd(3'd4, '0, 0, 0);
    check("R6 resume in idle ignored", int'({rdy_busy_n, arr_run}), 2);

    // R5: protection sweep
    prot_bits = 12'b1010_0101_1010;
    for (int s = 0; s < NS; s++) if (prot_bits[s]) begin
      do_cmd(3'd1, NS'(1) << s, 0, 8'h00);
      check("R5 no busy on protected program", int'({rdy_busy_n, arr_run}), 2);
      do_rd('0, 0, v);
      check("R5 error bit", int'(v[7:1]), 7'h01);
      do_cmd(3'd2, NS'(1) << s, 0, 8'h00);
      @(negedge clk);
      check("R5 no busy on protected erase", int'({rdy_busy_n, arr_run}), 2);
      for (int o = 0; o < NB; o++) begin
        do_rd(NS'(1) << s, OW'(o), v);
        check("R5 array unchanged", v, expm[s][o]);
      end
    end
    do_cmd(3'd1, NS'(1), 3, 8'h11);
    expm[0][3] = 8'h11;
    wait_ready(n);
    do_rd('0, 0, v);
    check("R5 error cleared", int'(v[7:1]), 0);
    prot_bits = '0;

    // R4: erase a boot sector
    r0 = run_cycles;
    do_cmd(3'd2, NS'(1) << 9, 0, 0);
    wait_ready(n);
    check("R4 busy cycles", n, ERASE_DUR + 1);
    for (int o = 0; o < NB; o++) expm[9][o] = 8'hFF;
    for (int s = 8; s < 11; s++)
      for (int o = 0; o < NB; o++) begin
        do_rd(NS'(1) << s, OW'(o), v);
        check("R4 erase scope", v, expm[s][o]);
      end

    // R7 / R8: suspend and resume an erase
    r0 = run_cycles;
    do_cmd(3'd2, NS'(1) << 3, 0, 0);
    repeat (3) @(negedge clk);
    do_cmd(3'd3, '0, 0, 0);
    check("R7 suspended pins", int'({rdy_busy_n, arr_run}), 2);
    do_rd('0, 0, v);
    check("R7 suspend bit", int'(v[7:1]), 7'h02);
    for (int o = 0; o < NB; o++) begin
      do_rd(NS'(1) << 5, OW'(o), v);
      check("R7 other sector readable", v, expm[5][o]);
    end
    do_rd(NS'(1) << 3, 0, v1);
    do_rd(NS'(1) << 3, 1, v2);
    check("R7 erasing sector gives status", int'(v1[7:1]), 7'h02);
    check("R10 toggle while suspended", int'(v1[0] ^ v2[0]), 1);
    do_cmd(3'd1, NS'(1) << 5, 0, 8'h00);
    do_rd(NS'(1) << 5, 0, v);
    check("R6 program while suspended ignored", v, expm[5][0]);
    check("R6 still suspended", int'({rdy_busy_n, arr_run}), 2);
    do_cmd(3'd4, '0, 0, 0);
    check("R8 resumed", int'({rdy_busy_n, arr_run}), 1);
    wait_ready(n);
    check("R8 total run cycles", run_cycles - r0, ERASE_DUR + 1);
    for (int s = 2; s < 5; s++) begin
      if (s == 3) for (int o = 0; o < NB; o++) expm[3][o] = 8'hFF;
      for (int o = 0; o < NB; o++) begin
        do_rd(NS'(1) << s, OW'(o), v);
        check("R8 erase result", v, expm[s][o]);
      end
    end

    // R11: identification mode
    prot_bits = 12'b0110_0011_0001;
    do_cmd(3'd5, '0, 0, 0);
    for (int s = 0; s < NS; s++) begin
      do_rd(NS'(1) << s, 0, v);
      check("R11 protect flag", v, int'(prot_bits[s]));
    end
    do_rd('0, 0, v);
    check("R11 device code", v, 8'hA5);
    do_cmd(3'd1, NS'(1) << 2, 0, 8'h00);
    check("R11 program ignored in id mode", int'(rdy_busy_n), 1);
    do_cmd(3'd6, '0, 0, 0);
    do_rd(NS'(1) << 2, 0, v);
    check("R11 back to array", v, expm[2][0]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule